// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement

This block holds the replacement history of a four-way set-associative cache. For every set it keeps three history bits arranged as a small binary tree. A root bit says which pair of ways was used most recently. Two leaf bits, one per pair, say which way inside that pair was used most recently. Whenever the cache reports a hit or completes a fill, it presents the set index and the way that was touched on a synchronous access port. The block then moves that set's tree so that it points away from the touched way.

On a miss, the cache controller asks which way to evict. It drives a set index and the four per-way valid bits on a combinational query port. The block answers in the same cycle. If any way in the set is empty, the answer is the lowest-numbered empty way. If all four ways are full, the block walks the tree toward the least recently touched side. The tag store, the data store and the refill path live outside this block. The set count is a parameter and defaults to 128 sets.

Top module: `plru4_repl`

## Requirements
- R1: After reset every history bit of every set is 0, so a query with all four ways valid (mask 4'hF) returns way 0 for any set.
- R2: An access to way 0 or way 1 sets the set's root bit to 1. An access to way 2 or way 3 clears it to 0.
- R3: An access to way 0 sets the set's left-pair bit to 1 and an access to way 1 clears it. Accesses to ways 2 and 3 leave the left-pair bit unchanged.
- R4: An access to way 2 sets the set's right-pair bit to 1 and an access to way 3 clears it. Accesses to ways 0 and 1 leave the right-pair bit unchanged.
- R5: With all ways valid and the root bit at 0, the victim comes from ways 0/1: left-pair bit 0 gives way 0 and left-pair bit 1 gives way 1.
- R6: With all ways valid and the root bit at 1, the victim comes from ways 2/3: right-pair bit 0 gives way 2 and right-pair bit 1 gives way 3.
- R7: If the valid mask (bit i belongs to way i, 1 means valid) has any zero bit, the victim is the lowest-numbered way whose bit is zero, whatever the history bits hold.
- R8: When an access and a query address the same set in the same cycle, the victim is computed from the history bits as they stood before that access.
- R9: An access changes only the addressed set. The history of every other set is left unchanged.
- R10: While the access valid input is low, no history bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; updates are taken on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all history |
| accValid | input | 1 | A hit or fill touched a way this cycle |
| accSet | input | SET_W | Set index of the touched line |
| accWay | input | 2 | Way number (0 to 3) of the touched line |
| qrySet | input | SET_W | Set index for the victim query |
| qryValidMask | input | 4 | Valid bits of the queried set, bit i for way i |
| victimWay | output | 2 | Way to replace in the queried set (combinational) |

## Verification
The assertions assume that the set indices stay below the set count and that the access port is free of X values once reset is released. The default of 128 sets fills the index width, so every index the stimulus draws is legal. The random stimulus weights the valid mask toward all-ones so that the tree decode is exercised often, and it only sometimes lands the query on the set being accessed. Directed cases cover the reset state, the same-cycle access and query, the isolation between sets, and idle cycles.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;

  // Strobes from control to the history datapath
  typedef struct packed {
    logic touch;     // write the root bit of the addressed set
    logic rootVal;   // new root value
    logic leftWr;    // write the left-pair bit
    logic leftVal;
    logic rightWr;   // write the right-pair bit
    logic rightVal;
  } updStrobe_t;
endpackage

// File: rtl/plru4_ctrl.sv
module plru4_ctrl
  import plru4_pkg::*;
(
  input  logic       accValid,
  input  way_t       accWay,
  output updStrobe_t strb
);
  // Point the tree away from the way just touched
  always_comb begin
    strb          = '0;
    strb.touch    = accValid;
    strb.rootVal  = ~accWay[1];
    strb.leftWr   = accValid & ~accWay[1];
    strb.leftVal  = ~accWay[0];
    strb.rightWr  = accValid & accWay[1];
    strb.rightVal = ~accWay[0];
  end
endmodule

// File: rtl/plru4_dpath.sv
module plru4_dpath
  import plru4_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  updStrobe_t       strb,
  input  logic [SET_W-1:0] accSet,
  input  logic [SET_W-1:0] qrySet,
  input  logic [WAYS-1:0]  qryValidMask,
  output way_t             victimWay
);
  logic [SETS-1:0] rootBits;
  logic [SETS-1:0] leftBits;
  logic [SETS-1:0] rightBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rootBits  <= '0;
      leftBits  <= '0;
      rightBits <= '0;
    end else if (strb.touch) begin
      rootBits[accSet] <= strb.rootVal;
      if (strb.leftWr)  leftBits[accSet]  <= strb.leftVal;
      if (strb.rightWr) rightBits[accSet] <= strb.rightVal;
    end
  end

  // Victim decode reads the registered bits, so a same-cycle update is not seen
  logic qRoot, qLeft, qRight;
  way_t treeWay;
  way_t freeWay;
  logic anyFree;

  always_comb begin
    qRoot   = rootBits[qrySet];
    qLeft   = leftBits[qrySet];
    qRight  = rightBits[qrySet];
    treeWay = qRoot ? {1'b1, qRight} : {1'b0, qLeft};
  end

  always_comb begin
    freeWay = '0;
    anyFree = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!qryValidMask[w]) begin
        freeWay = way_t'(w);
        anyFree = 1'b1;
      end
    end
  end

  assign victimWay = anyFree ? freeWay : treeWay;

  // An empty way is always the one returned
  assert_free_way_R7: assert property (@(posedge clk) disable iff (rst)
    (qryValidMask != 4'hF) |-> !qryValidMask[victimWay]);

  // With a full set the pair follows the root bit
  assert_pair_select_R5: assert property (@(posedge clk) disable iff (rst)
    ((qryValidMask == 4'hF) && !qRoot) |-> (victimWay[1] == 1'b0));

  assert_pair_select_R6: assert property (@(posedge clk) disable iff (rst)
    ((qryValidMask == 4'hF) && qRoot) |-> (victimWay[1] == 1'b1));

  // Updates on the other half of the tree leave a pair's bits alone
  assert_left_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.touch && !strb.leftWr) |=> $stable(leftBits));

  assert_right_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.touch && !strb.rightWr) |=> $stable(rightBits));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !strb.touch |=> ($stable(rootBits) && $stable(leftBits) && $stable(rightBits)));
endmodule

// File: rtl/plru4_repl.sv
module plru4_repl
  import plru4_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [1:0]       accWay,
  input  logic [SET_W-1:0] qrySet,
  input  logic [3:0]       qryValidMask,
  output logic [1:0]       victimWay
);
  updStrobe_t strb;

  plru4_ctrl u_ctrl (
    .accValid (accValid),
    .accWay   (accWay),
    .strb     (strb)
  );

  plru4_dpath #(.SETS(SETS), .SET_W(SET_W)) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .accSet       (accSet),
    .qrySet       (qrySet),
    .qryValidMask (qryValidMask),
    .victimWay    (victimWay)
  );

  // A way just touched is never the next victim of a full set
  assert_fresh_not_victim_R2: assert property (@(posedge clk) disable iff (rst)
    accValid |=> (!((qrySet == $past(accSet)) && (qryValidMask == 4'hF))
                  || (victimWay[1] != $past(accWay[1]))));
endmodule

// File: tb/plru4_repl_bench.sv
module plru4_repl_bench;
  localparam int SETS  = 128;
  localparam int SET_W = 7;

  logic             clk = 1'b0;
  logic             rst;
  logic             accValid;
  logic [SET_W-1:0] accSet;
  logic [1:0]       accWay;
  logic [SET_W-1:0] qrySet;
  logic [3:0]       qryValidMask;
  logic [1:0]       victimWay;

  int checks = 0;
  int errors = 0;

  bit mRoot  [SETS];
  bit mLeft  [SETS];
  bit mRight [SETS];

  always #4 clk = ~clk;

  plru4_repl #(.SETS(SETS), .SET_W(SET_W)) u_plru4_repl (
    .clk(clk), .rst(rst), .accValid(accValid), .accSet(accSet), .accWay(accWay),
    .qrySet(qrySet), .qryValidMask(qryValidMask), .victimWay(victimWay)
  );

  function automatic logic [1:0] expVictim(int s, logic [3:0] m);
    for (int w = 0; w < 4; w++) if (!m[w]) return 2'(w);
    if (mRoot[s]) return {1'b1, mRight[s]};
    return {1'b0, mLeft[s]};
  endfunction

  function automatic void modelTouch(int s, logic [1:0] w);
    mRoot[s] = !w[1];
    if (!w[1]) mLeft[s]  = !w[0];
    else       mRight[s] = !w[0];
  endfunction

  task automatic check(string tag, logic [1:0] expv);
    checks++;
    if (victimWay !== expv) begin
      errors++;
      $display("FAIL %s victim actual %0d expected %0d (set %0d mask %h)",
               tag, victimWay, expv, qrySet, qryValidMask);
    end
  endtask

  // One cycle: drive at negedge, check the combinational answer, then clock
  task automatic step(logic av, int as, logic [1:0] aw, int qs, logic [3:0] qm, string tag);
    @(negedge clk);
    accValid = av; accSet = SET_W'(as); accWay = aw;
    qrySet = SET_W'(qs); qryValidMask = qm;
    #1;
    check(tag, expVictim(qs, qm));
    @(posedge clk);
    if (av) modelTouch(as, aw);
  endtask

  task automatic query(int qs, logic [3:0] qm, string tag);
    step(1'b0, 0, 2'd0, qs, qm, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < SETS; s++) begin mRoot[s] = 0; mLeft[s] = 0; mRight[s] = 0; end
    rst = 1'b1; accValid = 0; accSet = '0; accWay = '0; qrySet = '0; qryValidMask = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, every set answers way 0
    for (int s = 0; s < SETS; s += 17) begin
      query(s, 4'hF, "R1");
      if (victimWay !== 2'd0) begin errors++; $display("FAIL R1 actual %0d expected 0", victimWay); end
      checks++;
    end

    // R2/R3: way 0 -> root 1, left 1 -> victim way 2 (R6)
    step(1'b1, 5, 2'd0, 5, 4'hF, "R8");
    query(5, 4'hF, "R2"); checks++;
    if (victimWay !== 2'd2) begin errors++; $display("FAIL R2 actual %0d expected 2", victimWay); end
    // R4/R6: way 2 -> root 0, right 1; left still 1 -> victim way 1 (R5, R3 hold)
    step(1'b1, 5, 2'd2, 5, 4'hF, "R6");
    query(5, 4'hF, "R3"); checks++;
    if (victimWay !== 2'd1) begin errors++; $display("FAIL R3 actual %0d expected 1", victimWay); end
    // way 1 -> root 1, left 0; right still 1 -> victim way 3
    step(1'b1, 5, 2'd1, 5, 4'hF, "R5");
    query(5, 4'hF, "R4"); checks++;
    if (victimWay !== 2'd3) begin errors++; $display("FAIL R4 actual %0d expected 3", victimWay); end

    // R8: same-cycle access and query see pre-update bits (victim 3 still)
    step(1'b1, 5, 2'd3, 5, 4'hF, "R8"); checks++;
    if (victimWay !== 2'd3) begin errors++; $display("FAIL R8 actual %0d expected 3", victimWay); end

    // R7: empty ways override the tree
    query(5, 4'b1011, "R7");
    query(5, 4'b0110, "R7");
    query(5, 4'b0111, "R7");

    // R9: neighbouring set untouched by accesses to set 5
    query(4, 4'hF, "R9"); checks++;
    if (victimWay !== 2'd0) begin errors++; $display("FAIL R9 actual %0d expected 0", victimWay); end
    query(6, 4'hF, "R9");

    // R10: idle cycles with changing set/way inputs leave history alone
    step(1'b0, 9, 2'd3, 9, 4'hF, "R10");
    step(1'b0, 9, 2'd0, 9, 4'hF, "R10"); checks++;
    if (victimWay !== 2'd0) begin errors++; $display("FAIL R10 actual %0d expected 0", victimWay); end

    // Random traffic over a small set window to build deep histories
    for (int i = 0; i < 4000; i++) begin
      logic av;
      int as, qs;
      logic [1:0] aw;
      logic [3:0] qm;
      av = ($urandom % 4) != 0;
      as = $urandom % 8;
      aw = 2'($urandom);
      qs = (($urandom % 4) == 0) ? as : ($urandom % 8);
      qm = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      if (qm != 4'hF)      step(av, as, aw, qs, qm, "R7");
      else if (mRoot[qs])  step(av, as, aw, qs, qm, "R6");
      else                 step(av, as, aw, qs, qm, "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule